// File: doc/BRIEF.md
# Branch Direction Predictor Table

This block guesses whether a conditional branch will be taken. It keeps a direct-mapped array of entries. Each entry holds a trained flag and a two-bit saturating confidence counter. The lookup side is purely combinational. The front end presents a branch address and the branch's signed displacement, and the block answers taken or not-taken in the same cycle.

The training side is driven when a branch commits. It receives the branch address and the real outcome, and it moves the addressed counter one step toward that outcome. Some entries have not been trained since reset or since the last flush. For those entries the table gives no opinion, and a static rule decides instead: backward branches (negative displacement) are predicted taken and forward branches are predicted not-taken. A synchronous flush forgets all training marks at once but keeps the counter values.

Top module: `bht_predictor`

## Requirements
- R1: The entry for an address is selected by address bits [IDX_W:1], where IDX_W = log2(ENTRIES) (bits [7:1] with the default of 128 entries). Addresses that differ by 2*ENTRIES share an entry. Addresses that differ by 2 use different entries.
- R2: After reset, every entry is untrained and its counter holds 0.
- R3: For an untrained entry, the prediction is taken exactly when bit OFF_W-1 (the sign bit) of the lookup displacement is 1.
- R4: For a trained entry, the prediction is taken exactly when its counter is 2 or 3. The displacement is ignored.
- R5: An update with outcome taken increments the addressed counter, and a counter at 3 stays at 3.
- R6: An update with outcome not-taken decrements the addressed counter, and a counter at 0 stays at 0.
- R7: An update marks the addressed entry trained from the next cycle on, unless a flush occurs in the same cycle.
- R8: The prediction depends combinationally on the current lookup inputs. When a lookup and an update hit the same entry in the same cycle, the lookup sees the value from before the update.
- R9: A flush makes every entry untrained from the next cycle on and leaves all counters unchanged. If an update arrives in the same cycle as a flush, it still trains the counter, but the entry stays untrained.
- R10: An update changes only the entry it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Clear all trained marks at the next edge |
| lk_pc_i | input | PC_W | Address of the branch being predicted |
| lk_offset_i | input | OFF_W | Signed displacement of the branch being predicted |
| lk_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_en_i | input | 1 | Commit-time training strobe |
| upd_pc_i | input | PC_W | Address of the committed branch |
| upd_taken_i | input | 1 | Resolved outcome of the committed branch, 1 = taken |

## Verification
The assertions check the following on every cycle, inside each entry:
- counter steps and saturation at both ends;
- setting of the trained flag;
- clearing of that flag by a flush;
- the counter staying unchanged when its entry is not addressed.

At the top, an assertion checks that the lookup falls back to the displacement sign right after a flush. Some behaviour appears only when the bench's reference model is compared with the prediction across scenarios:
- address aliasing between entries;
- the 2-or-3 threshold;
- read-before-write ordering of a same-cycle lookup and update;
- retention of counters across a flush.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX    = 2'd3;
  localparam ctr_t CTR_MIN    = 2'd0;
  localparam ctr_t CTR_THRESH = 2'd2;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t res;
    if (up) res = (cur == CTR_MAX) ? cur : cur + ctr_t'(1);
    else    res = (cur == CTR_MIN) ? cur : cur - ctr_t'(1);
    return res;
  endfunction
endpackage

// File: rtl/bht_index.sv
module bht_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 7
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  logic unused_pc_bits;

  // Halfword granularity: bit 0 is dropped so 16-bit branches get their own slot
  assign idx_o          = pc_i[IDX_W:1];
  assign unused_pc_bits = ^{pc_i[0], pc_i[PC_W-1:IDX_W+1]};
endmodule

// File: rtl/bht_entry.sv
module bht_entry
  import bht_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic wr_en_i,
  input  logic wr_taken_i,
  output logic valid_o,
  output ctr_t ctr_o
);
  logic valid_q, valid_d, valid_en;
  ctr_t ctr_q, ctr_d;
  logic ctr_en;

  always_comb begin
    ctr_en   = wr_en_i;
    ctr_d    = ctr_step(ctr_q, wr_taken_i);
    valid_en = wr_en_i | flush_i;
    valid_d  = ~flush_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ctr_q   <= CTR_MIN;
    end else begin
      if (valid_en) valid_q <= valid_d;
      if (ctr_en)   ctr_q   <= ctr_d;
    end
  end

  assign valid_o = valid_q;
  assign ctr_o   = ctr_q;

  AST_TRAIN_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !flush_i) |=> valid_q); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !valid_q); // R9
  AST_IDLE_HOLDS_CTR: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(ctr_q)); // R10
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_taken_i && ctr_q == CTR_MAX) |=> ctr_q == CTR_MAX); // R5
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_taken_i && ctr_q != CTR_MAX) |=> ctr_q == $past(ctr_q) + ctr_t'(1)); // R5
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_taken_i && ctr_q == CTR_MIN) |=> ctr_q == CTR_MIN); // R6
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_taken_i && ctr_q != CTR_MIN) |=> ctr_q == $past(ctr_q) - ctr_t'(1)); // R6
endmodule

// File: rtl/bht_lookup.sv
module bht_lookup
  import bht_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = 7
) (
  input  logic [ENTRIES-1:0]       valid_vec_i,
  input  logic [ENTRIES-1:0][1:0]  ctr_vec_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic                     off_neg_i,
  output logic                     taken_o
);
  logic sel_valid;
  ctr_t sel_ctr;

  always_comb begin
    sel_valid = valid_vec_i[idx_i];
    sel_ctr   = ctr_vec_i[idx_i];
    if (sel_valid) taken_o = (sel_ctr >= CTR_THRESH);
    else           taken_o = off_neg_i;
  end
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int PC_W    = 32,
  parameter int OFF_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  input  logic [OFF_W-1:0] lk_offset_i,
  output logic             lk_taken_o,
  input  logic             upd_en_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_taken_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0]       lk_idx, upd_idx;
  logic [ENTRIES-1:0]     valid_vec;
  logic [ENTRIES-1:0][1:0] ctr_vec;
  logic [ENTRIES-1:0]     wr_sel;
  logic                   lk_off_neg;
  logic                   unused_off_bits;

  assign lk_off_neg      = lk_offset_i[OFF_W-1];
  assign unused_off_bits = ^lk_offset_i[OFF_W-2:0];

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_index (
    .pc_i(lk_pc_i), .idx_o(lk_idx)
  );

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_index (
    .pc_i(upd_pc_i), .idx_o(upd_idx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    ctr_t ctr_w;
    assign wr_sel[g] = upd_en_i && (upd_idx == IDX_W'(g));
    bht_entry u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .wr_en_i    (wr_sel[g]),
      .wr_taken_i (upd_taken_i),
      .valid_o    (valid_vec[g]),
      .ctr_o      (ctr_w)
    );
    assign ctr_vec[g] = ctr_w;
  end

  bht_lookup #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lookup (
    .valid_vec_i (valid_vec),
    .ctr_vec_i   (ctr_vec),
    .idx_i       (lk_idx),
    .off_neg_i   (lk_off_neg),
    .taken_o     (lk_taken_o)
  );

  // The cycle after a flush nothing is trained, so the sign rule must decide
  AST_FLUSH_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_i) |-> (lk_taken_o == lk_offset_i[OFF_W-1])); // R9
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R10
endmodule

// File: tb/bht_predictor_bench.sv
module bht_predictor_bench;
  localparam int ENT = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i;
  logic [31:0] lk_pc_i, lk_offset_i, upd_pc_i;
  logic        lk_taken_o, upd_en_i, upd_taken_i;

  int errors = 0;
  int checks = 0;
  bit mv[ENT];
  int mc[ENT];

  always #5 clk = ~clk;

  bht_predictor u_bht_predictor (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .lk_pc_i(lk_pc_i), .lk_offset_i(lk_offset_i), .lk_taken_o(lk_taken_o),
    .upd_en_i(upd_en_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i)
  );

  function automatic int idx_of(input logic [31:0] pc);
    return int'((pc >> 1) % ENT);
  endfunction

  function automatic bit expect_taken(input logic [31:0] pc, input logic [31:0] off);
    int i = idx_of(pc);
    if (mv[i]) return mc[i] >= 2;
    return off[31];
  endfunction

  task automatic step(input logic [31:0] lpc, input logic [31:0] loff,
                      input bit uen, input logic [31:0] upc, input bit utk,
                      input bit fl, input string tag);
    bit exp;
    @(negedge clk);
    lk_pc_i = lpc; lk_offset_i = loff;
    upd_en_i = uen; upd_pc_i = upc; upd_taken_i = utk; flush_i = fl;
    #1;
    exp = expect_taken(lpc, loff);
    checks++;
    if (lk_taken_o !== exp) begin
      errors++;
      $display("FAIL %s: pc=%h off=%h taken=%b expected=%b", tag, lpc, loff, lk_taken_o, exp);
    end
    @(posedge clk);
    if (uen) begin
      int i = idx_of(upc);
      if (utk) begin if (mc[i] < 3) mc[i]++; end
      else     begin if (mc[i] > 0) mc[i]--; end
      mv[i] = 1'b1;
    end
    if (fl) for (int k = 0; k < ENT; k++) mv[k] = 1'b0;
  endtask

  localparam logic [31:0] NEG = 32'hFFFF_FFF0;
  localparam logic [31:0] POS = 32'h0000_0010;
  localparam logic [31:0] A   = 32'h0000_1234;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < ENT; k++) begin mv[k] = 1'b0; mc[k] = 0; end
    rst_n = 1'b0; flush_i = 1'b0; upd_en_i = 1'b0; upd_taken_i = 1'b0;
    lk_pc_i = '0; lk_offset_i = '0; upd_pc_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2 / R3: untrained everywhere, sign of displacement decides
    for (int k = 0; k < ENT; k++) begin
      step(32'(k * 2), POS, 0, 0, 0, 0, "R2");
      step(32'(k * 2), NEG, 0, 0, 0, 0, "R3");
    end

    // R7 / R4: one taken update -> trained, counter 1 -> not taken despite negative offset
    step(A, NEG, 1, A, 1, 0, "R8");
    step(A, NEG, 0, 0, 0, 0, "R4");
    // R5: climb and saturate
    for (int k = 0; k < 5; k++) step(A, POS, 1, A, 1, 0, "R5");
    step(A, POS, 1, A, 0, 0, "R5");
    step(A, POS, 0, 0, 0, 0, "R4");
    // R6: descend and saturate
    for (int k = 0; k < 5; k++) step(A, NEG, 1, A, 0, 0, "R6");
    step(A, NEG, 1, A, 1, 0, "R6");
    step(A, NEG, 0, 0, 0, 0, "R6");
    // R8: same-cycle lookup sees pre-update value (counter 1 -> 2)
    step(A, NEG, 1, A, 1, 0, "R8");
    step(A, NEG, 0, 0, 0, 0, "R8");

    // R1 / R10: alias and neighbour
    step(A + 32'd256, POS, 1, A + 32'd256, 1, 0, "R1");
    step(A, POS, 0, 0, 0, 0, "R1");
    step(A + 32'd2, NEG, 0, 0, 0, 0, "R10");
    step(A + 32'd2, POS, 1, A + 32'd2, 0, 0, "R10");
    step(A, POS, 0, 0, 0, 0, "R10");
    step(A + 32'd2, NEG, 0, 0, 0, 0, "R1");

    // R9: flush drops training, keeps counters
    step(A, POS, 0, 0, 0, 1, "R9");
    step(A, POS, 0, 0, 0, 0, "R9");
    step(A, NEG, 0, 0, 0, 0, "R9");
    step(A, NEG, 1, A, 0, 0, "R9");
    step(A, NEG, 0, 0, 0, 0, "R9");
    step(A, NEG, 1, A, 1, 1, "R9");
    step(A, NEG, 0, 0, 0, 0, "R9");
    step(A, POS, 1, A, 1, 0, "R9");
    step(A, POS, 0, 0, 0, 0, "R9");

    // Mixed traffic compared every cycle
    for (int k = 0; k < 600; k++) begin
      logic [31:0] lp, up, of;
      lp = {22'd0, 10'($urandom)};
      up = ($urandom % 3 == 0) ? lp : {22'd0, 10'($urandom)};
      of = $urandom;
      step(lp, of, 1'($urandom), up, 1'($urandom), ($urandom % 97) == 0, "R4");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule